// File: doc/BRIEF.md
# Serial Configuration PROM Readout Controller

This block is the read-side sequencer of a serial memory that streams a configuration bitstream into one or more programmable logic devices. It keeps a word address and a bit position, presents the word address to an external memory array, and shifts each returned word out one bit per clock, most significant bit first. The data pin is driven only while the block is selected and enabled; otherwise the enable is low and the pin can float.

The address space can be used whole or split into four equal partitions, chosen by a 2-bit selector when partitioning is enabled, so one memory can hold four independent bitstreams. When the last bit of the chosen range has been presented, a cascade enable output goes low so that the next memory in a daisy chain can continue the stream. A serial-mode input switches the readout path off while the memory is being programmed by other means. The memory is assumed to register its read address on the same clock edge as the counters, so the address port carries the address the counter will hold after that edge.

Top module: `cfg_prom_reader`

## Requirements
- R1: With partitioning on (`page_en_i`=1), a read starts at `page_sel_i` followed by ADDR_W-2 zero bits and ends at that value with the low ADDR_W-2 bits all ones; the word address never leaves that range.
- R2: With partitioning off, a read covers word addresses 0 to 2^ADDR_W-1 whatever `page_sel_i` holds.
- R3: On a clock edge with `ser_en_i`=1 and `oe_rst_i`=0 (whatever `ce_n_i` is), the bit position becomes 0 and the word address becomes the start of the range given by `page_en_i`/`page_sel_i` at that edge; those two inputs are sampled only at such an edge.
- R4: The counters advance on an edge only when `ser_en_i`=1, `ce_n_i`=0 and `oe_rst_i`=1; bit position runs 0 to WORD_W-1, the bit shown at position b is word bit WORD_W-1-b, and the word address steps by one as the position wraps to 0.
- R5: `dout_en_o` is 1 exactly when `ser_en_i`=1, `ce_n_i`=0 and `oe_rst_i`=1; with `ce_n_i`=1 and `oe_rst_i`=1 the counters do not move.
- R6: Once the last bit of the last word of the range is presented, the counters stay there (no wrap) until the next clear.
- R7: `ceo_n_o` is 0 exactly when the end of the range has been reached, `ser_en_i`=1, `ce_n_i`=0 and `oe_rst_i`=1; after a clear it stays 1 until the end is reached again.
- R8: With `ser_en_i`=0 the data enable is 0, `ceo_n_o` is 1, the counters hold, and `ce_n_i`, `oe_rst_i` and `page_sel_i` have no effect on the stream that resumes afterwards.
- R9: `mem_addr_o` equals the word address the counter will hold after the coming clock edge, so a memory that registers it returns the current word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_rst_i | input | 1 | High: output enable; low: counter clear |
| ser_en_i | input | 1 | 1 selects serial readout, 0 programming mode |
| page_en_i | input | 1 | 1 splits the address space into four partitions |
| page_sel_i | input | 2 | Partition choice |
| mem_addr_o | output | ADDR_W | Word address to the memory array |
| mem_rdata_i | input | WORD_W | Word returned by the memory array |
| dout_o | output | 1 | Serial data bit |
| dout_en_o | output | 1 | Drive enable for the serial data pin |
| ceo_n_o | output | 1 | Cascade enable to the next device, active low |

## Verification
The hardest state to reach is the end of a range followed by the cascade sequence: the enable must toggle after the counters have stopped, then a clear must come and the output must stay high through a whole new read. The bench reaches it by reading every partition setting to its end with random chip-enable pauses, then driving a directed toggle of `ce_n_i` and a clear. Programming mode is entered mid-stream with random enable, clear and partition inputs, and the stream must resume where it stopped; the partition selector is also randomised every cycle to show it is sampled only at a clear.

// File: rtl/cfg_prom_pkg.sv
package cfg_prom_pkg;

  localparam int PAGE_SEL_W = 2;

  typedef struct packed {
    logic                  paged;
    logic [PAGE_SEL_W-1:0] sel;
  } page_sel_t;

endpackage

// File: rtl/cfg_page_decode.sv
module cfg_page_decode
  import cfg_prom_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                  clk_i,
  input  logic                  load_i,
  input  logic                  page_en_i,
  input  logic [PAGE_SEL_W-1:0] page_sel_i,
  output logic [ADDR_W-1:0]     base_next_o,
  output logic [ADDR_W-1:0]     base_o,
  output logic [ADDR_W-1:0]     top_o
);

  localparam int OFF_W = ADDR_W - PAGE_SEL_W;
  localparam logic [ADDR_W-1:0] PAGE_MASK = {{PAGE_SEL_W{1'b0}}, {OFF_W{1'b1}}};

  function automatic logic [ADDR_W-1:0] range_start(input page_sel_t p);
    logic [ADDR_W-1:0] r;
    r = '0;
    if (p.paged) r[ADDR_W-1 -: PAGE_SEL_W] = p.sel;
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] range_end(input page_sel_t p);
    return range_start(p) | (p.paged ? PAGE_MASK : {ADDR_W{1'b1}});
  endfunction

  page_sel_t page_in;
  page_sel_t page_q;

  assign page_in = '{paged: page_en_i, sel: page_sel_i};

  always_ff @(posedge clk_i) begin
    if (load_i) page_q <= page_in;
  end

  assign base_next_o = range_start(page_in);
  assign base_o      = range_start(page_q);
  assign top_o       = range_end(page_q);

endmodule

// File: rtl/cfg_read_counter.sv
module cfg_read_counter #(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 16
) (
  input  logic                     clk_i,
  input  logic                     clear_i,
  input  logic                     run_i,
  input  logic [ADDR_W-1:0]        base_next_i,
  input  logic [ADDR_W-1:0]        top_i,
  output logic [ADDR_W-1:0]        addr_q_o,
  output logic [ADDR_W-1:0]        addr_next_o,
  output logic [$clog2(WORD_W)-1:0] bit_q_o,
  output logic                     at_end_o
);

  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  logic [ADDR_W-1:0] addr_q;
  logic [BIT_W-1:0]  bit_q;
  logic              step;
  logic              word_wrap;

  assign at_end_o    = (addr_q == top_i) && (bit_q == LAST_BIT);
  assign step        = run_i && !at_end_o;
  assign word_wrap   = step && (bit_q == LAST_BIT);
  assign addr_next_o = clear_i   ? base_next_i :
                       word_wrap ? addr_q + ADDR_W'(1) : addr_q;

  always_ff @(posedge clk_i) begin
    addr_q <= addr_next_o;
    if (clear_i)        bit_q <= '0;
    else if (word_wrap) bit_q <= '0;
    else if (step)      bit_q <= bit_q + BIT_W'(1);
  end

  assign addr_q_o = addr_q;
  assign bit_q_o  = bit_q;

  AST_CLEAR_LOAD: assert property (@(posedge clk_i) disable iff (clear_i)
    $past(clear_i) |-> (bit_q == '0) && (addr_q == $past(base_next_i))); // R3

  AST_BIT_STEP: assert property (@(posedge clk_i) disable iff (clear_i)
    (run_i && !at_end_o && bit_q != LAST_BIT) |=>
      (bit_q == $past(bit_q) + BIT_W'(1)) && $stable(addr_q)); // R4

  AST_FROZEN_IDLE: assert property (@(posedge clk_i) disable iff (clear_i)
    !run_i |=> $stable(addr_q) && $stable(bit_q)); // R5

  AST_HOLD_AT_END: assert property (@(posedge clk_i) disable iff (clear_i)
    at_end_o |=> $stable(addr_q) && $stable(bit_q)); // R6

endmodule

// File: rtl/cfg_cascade.sv
module cfg_cascade #(
  parameter int WORD_W = 16
) (
  input  logic                      ser_en_i,
  input  logic                      ce_n_i,
  input  logic                      oe_rst_i,
  input  logic                      at_end_i,
  input  logic [$clog2(WORD_W)-1:0] bit_i,
  input  logic [WORD_W-1:0]         word_i,
  output logic                      dout_o,
  output logic                      dout_en_o,
  output logic                      ceo_n_o
);

  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  logic selected;

  assign selected  = ser_en_i && !ce_n_i && oe_rst_i;
  assign dout_en_o = selected;
  assign dout_o    = selected && word_i[LAST_BIT - bit_i];
  assign ceo_n_o   = !(selected && at_end_i);

endmodule

// File: rtl/cfg_prom_reader.sv
module cfg_prom_reader
  import cfg_prom_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 16
) (
  input  logic                  clk_i,
  input  logic                  ce_n_i,
  input  logic                  oe_rst_i,
  input  logic                  ser_en_i,
  input  logic                  page_en_i,
  input  logic [PAGE_SEL_W-1:0] page_sel_i,
  output logic [ADDR_W-1:0]     mem_addr_o,
  input  logic [WORD_W-1:0]     mem_rdata_i,
  output logic                  dout_o,
  output logic                  dout_en_o,
  output logic                  ceo_n_o
);

  localparam int BIT_W = $clog2(WORD_W);

  logic              clear;
  logic              run;
  logic [ADDR_W-1:0] base_next;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] top_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BIT_W-1:0]  bit_q;
  logic              at_end;

  assign clear = ser_en_i && !oe_rst_i;
  assign run   = ser_en_i && !ce_n_i && oe_rst_i;

  cfg_page_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk_i      (clk_i),
    .load_i     (clear),
    .page_en_i  (page_en_i),
    .page_sel_i (page_sel_i),
    .base_next_o(base_next),
    .base_o     (base_q),
    .top_o      (top_q)
  );

  cfg_read_counter #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_counter (
    .clk_i      (clk_i),
    .clear_i    (clear),
    .run_i      (run),
    .base_next_i(base_next),
    .top_i      (top_q),
    .addr_q_o   (addr_q),
    .addr_next_o(mem_addr_o),
    .bit_q_o    (bit_q),
    .at_end_o   (at_end)
  );

  cfg_cascade #(.WORD_W(WORD_W)) u_cascade (
    .ser_en_i (ser_en_i),
    .ce_n_i   (ce_n_i),
    .oe_rst_i (oe_rst_i),
    .at_end_i (at_end),
    .bit_i    (bit_q),
    .word_i   (mem_rdata_i),
    .dout_o   (dout_o),
    .dout_en_o(dout_en_o),
    .ceo_n_o  (ceo_n_o)
  );

  AST_ADDR_IN_PAGE: assert property (@(posedge clk_i) disable iff (clear)
    (addr_q >= base_q) && (addr_q <= top_q)); // R1

  AST_CEO_AT_TOP: assert property (@(posedge clk_i) disable iff (clear)
    !ceo_n_o |-> (mem_addr_o == top_q)); // R7

  AST_PROG_QUIET: assert property (@(posedge clk_i) disable iff (clear)
    !ser_en_i |-> !dout_en_o && ceo_n_o && (mem_addr_o == addr_q)); // R8

endmodule

// File: tb/cfg_prom_reader_bench.sv
module cfg_prom_reader_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int WW = 4;
  localparam int QUARTER = 1 << (AW - 2);

  logic          clk = 1'b0;
  logic          ce_n = 1'b1;
  logic          oe = 1'b0;
  logic          ser = 1'b1;
  logic          pen = 1'b0;
  logic [1:0]    sel = 2'b00;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] rdata;
  logic          dout, dout_en, ceo_n;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  // model state: linear bit index within the selected range
  bit m_valid = 1'b0;
  bit m_paged = 1'b0;
  int m_sel   = 0;
  int idx     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_prom_reader #(.ADDR_W(AW), .WORD_W(WW)) u_cfg_prom_reader (
    .clk_i(clk), .ce_n_i(ce_n), .oe_rst_i(oe), .ser_en_i(ser),
    .page_en_i(pen), .page_sel_i(sel), .mem_addr_o(mem_addr),
    .mem_rdata_i(rdata), .dout_o(dout), .dout_en_o(dout_en), .ceo_n_o(ceo_n)
  );

  function automatic logic [WW-1:0] rom_word(input int a);
    int h;
    h = a * 37 + 11;
    h = h ^ (h >> 3);
    return h[WW-1:0];
  endfunction

  // registered-read memory
  always @(posedge clk) rdata <= rom_word(int'(mem_addr));

  function automatic int start_of(input bit paged, input int s);
    return paged ? s * QUARTER : 0;
  endfunction

  function automatic int last_idx(input bit paged);
    return (paged ? QUARTER : (1 << AW)) * WW - 1;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (idx %0d, t=%0t)", tag, act, exp, idx, $time);
    end
  endtask

  task automatic cyc(input logic c, input logic o, input logic s, input logic pe, input logic [1:0] ps);
    int cur, nxt, bpos;
    bit selected, clr;
    logic [WW-1:0] w;
    ce_n = c; oe = o; ser = s; pen = pe; sel = ps;
    #1;
    selected = s && !c && o;
    clr = s && !o;
    if (m_valid) begin
      cur  = start_of(m_paged, m_sel) + idx / WW;
      bpos = idx % WW;
      w    = rom_word(cur);
      check(s ? "R5 dout_en" : "R8 dout_en", int'(dout_en), int'(selected));
      if (selected) begin
        if (idx == last_idx(m_paged)) check("R6 dout at end", int'(dout), int'(w[WW-1-bpos]));
        else if (m_paged)             check("R1 dout paged", int'(dout), int'(w[WW-1-bpos]));
        else                          check("R2 dout full", int'(dout), int'(w[WW-1-bpos]));
      end
      check(s ? "R7 ceo_n" : "R8 ceo_n", int'(ceo_n),
            int'(!(selected && idx == last_idx(m_paged))));
      if (clr) nxt = start_of(pe, int'(ps));
      else if (selected && idx < last_idx(m_paged) && bpos == WW - 1) nxt = cur + 1;
      else nxt = cur;
      check(clr ? "R3 mem_addr" : "R9 mem_addr", int'(mem_addr), nxt);
    end
    @(posedge clk);
    if (clr) begin
      m_valid = 1'b1; m_paged = pe; m_sel = int'(ps); idx = 0;
    end else if (m_valid && selected && idx < last_idx(m_paged)) begin
      idx++;
    end
    @(negedge clk);
  endtask

  task automatic read_range(input logic pe, input logic [1:0] ps);
    cyc(1'b0, 1'b0, 1'b1, pe, ps);
    cyc(1'b1, 1'b0, 1'b1, pe, ps);
    // R4: stream with random enable pauses, selector noise ignored (R3)
    while (idx < last_idx(m_paged))
      cyc(($urandom % 4) == 0, 1'b1, 1'b1, $urandom % 2, 2'($urandom));
    for (int k = 0; k < 4; k++) cyc(1'b0, 1'b1, 1'b1, $urandom % 2, 2'($urandom));
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 2'b00);
    check("R5 reset enable", int'(dout_en), 0);
    check("R7 reset ceo_n", int'(ceo_n), 1);
    for (int s = 0; s < 4; s++) read_range(1'b1, 2'(s));
    read_range(1'b0, 2'b00);
    read_range(1'b0, 2'b11);
    // R7: cascade follows ce_n after the end, then locks high after a clear
    for (int k = 0; k < 6; k++) cyc(k % 2 == 0, 1'b1, 1'b1, 1'b1, 2'b01);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 2'b10);
    for (int k = 0; k < 20; k++) cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'b00);
    check("R7 ceo_n after clear", int'(ceo_n), 1);
    // R8: programming mode mid-stream, then resume in the same range
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 2'b10);
    for (int k = 0; k < 21; k++) cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'b00);
    for (int k = 0; k < 12; k++)
      cyc($urandom % 2, $urandom % 2, 1'b0, $urandom % 2, 2'($urandom));
    check("R8 resumed index", idx, 21);
    while (idx < last_idx(m_paged)) cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'b11);
    for (int k = 0; k < 3; k++) cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'b11);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule